// File: doc/BRIEF.md
# Auto-Ranging Frequency Counter

This block measures the frequency of an asynchronous digital input. It counts rising edges over a fixed gate window, timed in system clock cycles, and reports the count with a range code and a matching decimal-point code. The input first passes a synchroniser and an edge detector. It then goes through a decade prescaler whose tap, divide by 1, 10, 100 or 1000 by default, is set by the current range.

At the end of each window the block publishes the reading and pulses a valid strobe for one cycle. It then decides the range for the next window. An overflowing reading moves the range one decade coarser. A reading below a low threshold moves it one decade finer. When the range cannot move, or peak hold has frozen it, an overflowing reading is reported as over-range with the count saturated. A display or a host samples the outputs on the valid strobe.

Top module: `freq_autorange`

## Requirements
- R1: `valid_o` is high for exactly one clock per window. The windows are `GATE_CYCLES` clocks long, and the first strobe comes `GATE_CYCLES` clocks after reset is released.
- R2: On a stable input, a window at range r reports floor(E / DECADE^r). E is the number of rising edges of `freq_in` that fell inside that window.
- R3: When the reading exceeds `MAX_COUNT` on any range but the coarsest, and peak hold is off, the result shows `count_o = MAX_COUNT` with `ovr_o = 0`. The next window uses range r+1.
- R4: When the reading is below `LOW_COUNT` on any range above 0, and peak hold is off, the next window uses range r-1. Ranges only ever move by one step per window.
- R5: An overflow on the coarsest range reports `count_o = MAX_COUNT` and `ovr_o = 1`, and the range stays put.
- R6: While `peak_hold` is high at a window's end, the range does not change. An overflow in that window reports `count_o = MAX_COUNT` with `ovr_o = 1`, on any range.
- R7: `range_o` gives the range used for the reading, with 0 meaning divide by 1. `dp_o` has bit NUM_RANGES-2-r set for range r < NUM_RANGES-1 and is all zero on the coarsest range. With four ranges, ranges 0..3 give 3'b100, 3'b010, 3'b001 and 3'b000.
- R8: During reset `count_o`, `range_o`, `ovr_o` and `valid_o` are 0, so `dp_o` shows the finest-range code.
- R9: `freq_in` may be asynchronous. It is synchronised through two flops, and each rising edge is counted once, even when high and low each last a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also times the gate window |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_in | input | 1 | Frequency input to be measured, asynchronous |
| peak_hold | input | 1 | Freezes automatic range selection while high |
| count_o | output | $clog2(MAX_COUNT+1) | Reading of the last window, saturated at MAX_COUNT |
| range_o | output | $clog2(NUM_RANGES) | Range used for the last reading |
| dp_o | output | NUM_RANGES-1 | One-hot decimal-point code, zero on the coarsest range |
| ovr_o | output | 1 | Reading exceeded full scale and the range could not step |
| valid_o | output | 1 | One-clock strobe when a new reading is published |

## Verification
The bench drives periodic inputs whose periods divide the window. The edge count per window is then exact, and each period lands in a different steady range and reading. The fastest toggle, one clock high and one low, checks the synchroniser and the overflow on the coarsest range. Readings exactly at the low threshold separate the threshold comparison from an off-by-one. Directed sequences walk the range up from reset and down after peak hold is released, one window at a time. They show single steps, the saturated count that does not set over-range, and that a frozen range reports over-range even on the finest decade.

// File: rtl/far_pkg.sv
package far_pkg;
   typedef enum logic [1:0] {
      STEP_KEEP    = 2'd0,
      STEP_COARSER = 2'd1,
      STEP_FINER   = 2'd2
   } step_e;
endpackage

// File: rtl/far_sync_edge.sv
module far_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   // SYNC_STAGES flops of synchroniser plus one of history for edge detection
   logic [SYNC_STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], async_i};
   end

   assign rise_o = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
endmodule

// File: rtl/far_prescale.sv
module far_prescale #(
   parameter int STAGES = 3,
   parameter int DECADE = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            edge_i,
   output logic [STAGES:0] tap_o
);
   localparam int DW = $clog2(DECADE);

   assign tap_o[0] = edge_i;

   genvar k;
   generate
      for (k = 0; k < STAGES; k++) begin : g_stage
         logic [DW-1:0] cnt;
         logic          wrap;
         assign wrap       = (cnt == DW'(DECADE - 1));
         assign tap_o[k+1] = tap_o[k] & wrap & ~restart;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (restart)
               // an edge in the closing cycle belongs to the next window
               cnt <= (k == 0 && edge_i) ? DW'(1) : '0;
            else if (tap_o[k])
               cnt <= wrap ? '0 : cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/far_gate.sv
module far_gate #(
   parameter int GATE_CYCLES = 40000
) (
   input  logic clk,
   input  logic rst_n,
   output logic win_end
);
   localparam int GW = $clog2(GATE_CYCLES);
   logic [GW-1:0] cnt;

   assign win_end = (cnt == GW'(GATE_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (win_end) cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/far_range_ctl.sv
module far_range_ctl
   import far_pkg::*;
#(
   parameter int NUM_RANGES = 4,
   localparam int RW = $clog2(NUM_RANGES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_end,
   input  logic          over,
   input  logic          low,
   input  logic          hold,
   output logic [RW-1:0] rng_q,
   output logic [RW-1:0] rng_nx,
   output step_e         step
);
   localparam logic [RW-1:0] TOP = RW'(NUM_RANGES - 1);

   always_comb begin
      if (hold)                          step = STEP_KEEP;
      else if (over && rng_q != TOP)     step = STEP_COARSER;
      else if (low && rng_q != '0)       step = STEP_FINER;
      else                               step = STEP_KEEP;
   end

   always_comb begin
      unique case (step)
         STEP_COARSER: rng_nx = rng_q + 1'b1;
         STEP_FINER:   rng_nx = rng_q - 1'b1;
         default:      rng_nx = rng_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rng_q <= '0;
      else if (win_end) rng_q <= rng_nx;
   end
endmodule

// File: rtl/freq_autorange.sv
module freq_autorange
   import far_pkg::*;
#(
   parameter int GATE_CYCLES = 40000,
   parameter int MAX_COUNT   = 3999,
   parameter int LOW_COUNT   = 400,
   parameter int NUM_RANGES  = 4,
   parameter int DECADE      = 10,
   parameter int SYNC_STAGES = 2,
   localparam int CW  = $clog2(MAX_COUNT + 1),
   localparam int RW  = $clog2(NUM_RANGES),
   localparam int DPW = NUM_RANGES - 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           freq_in,
   input  logic           peak_hold,
   output logic [CW-1:0]  count_o,
   output logic [RW-1:0]  range_o,
   output logic [DPW-1:0] dp_o,
   output logic           ovr_o,
   output logic           valid_o
);
   localparam int AW = $clog2(MAX_COUNT + 2);

   generate
      if (NUM_RANGES < 2)       begin : g_bad_nr   $error("NUM_RANGES must be at least 2");    end
      if (DECADE < 2)           begin : g_bad_dec  $error("DECADE must be at least 2");        end
      if (GATE_CYCLES < 2)      begin : g_bad_gate $error("GATE_CYCLES must be at least 2");   end
      if (LOW_COUNT > MAX_COUNT) begin : g_bad_low $error("LOW_COUNT may not exceed MAX_COUNT"); end
      if (SYNC_STAGES < 2)      begin : g_bad_sync $error("SYNC_STAGES must be at least 2");   end
   endgenerate

   logic                  edge_w, win_end, sel_pulse, over, low;
   logic [NUM_RANGES-1:0] tap;
   logic [RW-1:0]         rng_q, rng_nx;
   logic [AW-1:0]         acc;
   step_e                 step;

   far_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(freq_in), .rise_o(edge_w)
   );

   far_prescale #(.STAGES(NUM_RANGES - 1), .DECADE(DECADE)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(win_end), .edge_i(edge_w), .tap_o(tap)
   );

   far_gate #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
      .clk(clk), .rst_n(rst_n), .win_end(win_end)
   );

   far_range_ctl #(.NUM_RANGES(NUM_RANGES)) u_rng (
      .clk(clk), .rst_n(rst_n), .win_end(win_end), .over(over), .low(low),
      .hold(peak_hold), .rng_q(rng_q), .rng_nx(rng_nx), .step(step)
   );

   assign sel_pulse = tap[rng_q];
   assign over      = (acc > AW'(MAX_COUNT));
   assign low       = (acc < AW'(LOW_COUNT));

   // window accumulator, saturating one above full scale
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (win_end)
         acc <= (rng_nx == '0 && edge_w) ? AW'(1) : '0;
      else if (sel_pulse && acc <= AW'(MAX_COUNT))
         acc <= acc + 1'b1;
   end

   // published result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= '0;
         range_o <= '0;
         ovr_o   <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= win_end;
         if (win_end) begin
            count_o <= over ? CW'(MAX_COUNT) : acc[CW-1:0];
            range_o <= rng_q;
            ovr_o   <= over && (step != STEP_COARSER);
         end
      end
   end

   genvar r;
   generate
      for (r = 0; r < NUM_RANGES - 1; r++) begin : g_dp
         assign dp_o[NUM_RANGES-2-r] = (range_o == RW'(r));
      end
   endgenerate
endmodule

// File: rtl/far_chk.sv
module far_chk #(
   parameter int GATE_CYCLES = 40000,
   parameter int MAX_COUNT   = 3999,
   parameter int NUM_RANGES  = 4,
   localparam int CW  = $clog2(MAX_COUNT + 1),
   localparam int RW  = $clog2(NUM_RANGES),
   localparam int DPW = NUM_RANGES - 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           peak_hold,
   input logic [CW-1:0]  count_o,
   input logic [RW-1:0]  range_o,
   input logic [DPW-1:0] dp_o,
   input logic           ovr_o,
   input logic           valid_o
);
   localparam int TW = $clog2(GATE_CYCLES) + 1;
   localparam logic [RW-1:0] TOP = RW'(NUM_RANGES - 1);

   logic [TW-1:0] gap;
   logic          seen, hold_q, last_hold;
   logic [RW-1:0] prev_rng;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap       <= '0;
         seen      <= 1'b0;
         hold_q    <= 1'b0;
         last_hold <= 1'b0;
         prev_rng  <= '0;
      end else begin
         hold_q <= peak_hold;
         if (valid_o) begin
            gap       <= '0;
            seen      <= 1'b1;
            prev_rng  <= range_o;
            last_hold <= hold_q;
         end else if (gap != '1) begin
            gap <= gap + 1'b1;
         end
      end
   end

   AST_VALID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && seen |-> gap == TW'(GATE_CYCLES - 1));                      // R1
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);                                                 // R1
   AST_RANGE_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(range_o) |-> valid_o);                                        // R3
   AST_RANGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && seen |-> ({1'b0, range_o} == {1'b0, prev_rng}) ||
                          ({1'b0, range_o} == {1'b0, prev_rng} + 1'b1) ||
                          ({1'b0, range_o} + 1'b1 == {1'b0, prev_rng}));     // R4
   AST_OVR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |-> count_o == CW'(MAX_COUNT));                                  // R5
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && seen && last_hold |-> range_o == prev_rng);                 // R6
   AST_DP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dp_o) && ((dp_o == '0) == (range_o == TOP)));                 // R7
endmodule

bind freq_autorange far_chk #(
   .GATE_CYCLES(GATE_CYCLES),
   .MAX_COUNT(MAX_COUNT),
   .NUM_RANGES(NUM_RANGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .peak_hold(peak_hold), .count_o(count_o),
   .range_o(range_o), .dp_o(dp_o), .ovr_o(ovr_o), .valid_o(valid_o)
);

// File: tb/sim_freq_autorange.sv
module sim_freq_autorange;
   localparam int G   = 2000;
   localparam int MX  = 9;
   localparam int LO  = 1;
   localparam int NR  = 3;
   localparam int CW  = $clog2(MX + 1);
   localparam int RW  = $clog2(NR);
   localparam int DPW = NR - 1;

   // period in clocks, expected count, expected range, expected over-range
   localparam int VEC [9][4] = '{
      '{2, 9, 2, 1}, '{4, 5, 2, 0}, '{8, 2, 2, 0}, '{20, 1, 2, 0}, '{25, 8, 1, 0},
      '{200, 1, 1, 0}, '{250, 8, 0, 0}, '{500, 4, 0, 0}, '{0, 0, 0, 0}
   };

   logic clk = 1'b0, rst_n = 1'b0, freq_in = 1'b0, peak_hold = 1'b0;
   logic [CW-1:0]  count_o;
   logic [RW-1:0]  range_o;
   logic [DPW-1:0] dp_o;
   logic           ovr_o, valid_o;
   int total = 0, bad = 0, per = 4;

   always #10 clk = ~clk;

   freq_autorange #(.GATE_CYCLES(G), .MAX_COUNT(MX), .LOW_COUNT(LO), .NUM_RANGES(NR)) u0 (
      .clk(clk), .rst_n(rst_n), .freq_in(freq_in), .peak_hold(peak_hold),
      .count_o(count_o), .range_o(range_o), .dp_o(dp_o), .ovr_o(ovr_o), .valid_o(valid_o)
   );

   initial begin : gen
      forever begin
         if (per == 0) begin
            freq_in = 1'b0;
            @(negedge clk);
         end else begin
            freq_in = 1'b1;
            repeat (per / 2) @(negedge clk);
            freq_in = 1'b0;
            repeat (per - per / 2) @(negedge clk);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int dp_exp(input int r);
      return (r < NR - 1) ? (1 << (NR - 2 - r)) : 0;
   endfunction

   task automatic chk_res(input string req, input int c, input int r, input int o);
      chk(req, "count", int'(count_o), c);
      chk(req, "range", int'(range_o), r);
      chk(req, "dp", int'(dp_o), dp_exp(r));
      chk(req, "ovr", int'(ovr_o), o);
   endtask

   task automatic wait_valid();
      @(negedge clk);
      while (!valid_o) @(negedge clk);
   endtask

   task automatic settle();
      int pc, pr, po;
      wait_valid();
      wait_valid();
      pc = int'(count_o); pr = int'(range_o); po = int'(ovr_o);
      for (int i = 0; i < 6; i++) begin
         wait_valid();
         if (int'(count_o) == pc && int'(range_o) == pr && int'(ovr_o) == po) break;
         pc = int'(count_o); pr = int'(range_o); po = int'(ovr_o);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin : main
      int n;
      repeat (4) @(negedge clk);
      chk_res("R8", 0, 0, 0);
      chk("R8", "valid in reset", int'(valid_o), 0);
      rst_n = 1'b1;

      // first window timing and upward walk from range 0 (E = 500)
      n = 0;
      do begin @(negedge clk); n++; end while (!valid_o);
      chk("R1", "cycles to first strobe", n, G);
      chk_res("R3", 9, 0, 0);
      @(negedge clk);
      chk("R1", "strobe width", int'(valid_o), 0);
      n = 1;
      while (!valid_o) begin @(negedge clk); n++; end
      chk("R1", "window length", n, G);
      chk_res("R3", 9, 1, 0);
      wait_valid(); chk_res("R2", 5, 2, 0);
      wait_valid(); chk_res("R2", 5, 2, 0);

      // frozen range, then downward walk after release (E = 8)
      peak_hold = 1'b1; per = 250;
      wait_valid(); wait_valid();
      chk_res("R6", 0, 2, 0);
      peak_hold = 1'b0;
      wait_valid(); chk_res("R4", 0, 2, 0);
      wait_valid(); chk_res("R4", 0, 1, 0);
      wait_valid(); chk_res("R4", 8, 0, 0);

      // overflow under hold on the finest range (E = 500)
      peak_hold = 1'b1; per = 4;
      wait_valid(); wait_valid();
      chk_res("R6", 9, 0, 1);
      peak_hold = 1'b0;
      wait_valid(); chk_res("R3", 9, 0, 0);
      wait_valid(); chk_res("R3", 9, 1, 0);
      wait_valid(); chk_res("R2", 5, 2, 0);

      // reset in the middle of a run
      rst_n = 1'b0;
      @(negedge clk);
      chk_res("R8", 0, 0, 0);
      chk("R8", "valid in reset", int'(valid_o), 0);
      rst_n = 1'b1;

      // steady readings for a set of periods
      for (int v = 0; v < 9; v++) begin
         per = VEC[v][0];
         settle();
         if (VEC[v][0] == 2) chk_res("R5 R9", VEC[v][1], VEC[v][2], VEC[v][3]);
         else                chk_res("R2 R7", VEC[v][1], VEC[v][2], VEC[v][3]);
      end

      finish_run();
   end
endmodule